// File: doc/BRIEF.md
# Byte-Wide Memory Chip-Enable Decoder

This block takes one access per clock from a processor core: a 16-bit logical address, a strobe, and flags that say whether the access is a program fetch or a data access and whether it is a write. It turns that access into the control lines of a non-multiplexed byte-wide memory bus. These are four active-low memory chip enables, four active-low peripheral enables, an active-low write strobe and a 15-bit byte address. All outputs are registered and change in the cycle after the strobe.

A mode pin selects the memory build. It is either four 32 KB parts, one per chip enable, or a single 128 KB part. In the single-part build, two of the enable pins carry the two top address bits. A partition input with 2 KB granularity splits the logical space. Program fetches below the partition and data accesses at or above it reach the shared memory. Any other access raises an expanded-bus flag and drives no enable. A peripheral-select bit sends every data access to one of four peripheral enables, chosen by address quarter. Program space is always write-protected. An inhibit input, driven by reset or power-fail logic, forces every control line inactive.

Top module: `bw_decoder`

## Requirements
- R1: While `rst` is high, and at the first sample after it, every `ce_n`, `pe_n` and `wr_n` line is 1, `ext_sel` is 0 and `ba` is 0. Every other output below is registered and appears in the cycle after the access.
- R2: With `mem_big` = 1 (four 32 KB parts), a memory access drives exactly one `ce_n` bit low. The bit index is {is_data, addr[15]}: bit 0 for program below 8000h, bit 1 for program at 8000h or above, bit 2 for data below 8000h, and bit 3 for data at 8000h or above.
- R3: With `mem_big` = 0 (one 128 KB part), a memory access drives `ce_n[0]` low. `ce_n[1]` carries the A16 value (1 for data, 0 for program) and `ce_n[2]` carries A15 (addr[15]). `ce_n[3]` stays 1 in this mode at all times.
- R4: With limit = `part_blk` × 2048 (`part_blk` is 6 bits), a program fetch reaches memory only when addr < limit. A data access reaches memory only when addr ≥ limit.
- R5: With `periph_sel` = 1, a data access drives `pe_n[addr[15:14]]` low and no `ce_n`, whatever the partition. Program fetches are unaffected by `periph_sel`.
- R6: `wr_n` goes low only for a strobed write to a data memory location or to a peripheral. A program fetch with `wr` = 1 still leaves `wr_n` at 1.
- R7: `ba` takes addr[14:0] in the cycle after each strobe and holds its value when the strobe is low.
- R8: An access that is neither a peripheral access nor within its partition range drives `ext_sel` to 1, leaves all enables at 1 and leaves `wr_n` at 1.
- R9: An access made while `inhibit` is 1 leaves every enable and `wr_n` at 1 and `ext_sel` at 0.
- R10: A cycle with `strobe` = 0 leaves every enable and `wr_n` at 1 and `ext_sel` at 0.
- R11: At most one line is low among the eight enables in the 32 KB build. In the 128 KB build, the same holds for `ce_n[0]`, `ce_n[3]` and `pe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Access valid this cycle |
| addr | input | 16 | Logical address |
| is_prog | input | 1 | 1 = program fetch, 0 = data access |
| wr | input | 1 | 1 = write |
| mem_big | input | 1 | 1 = four 32 KB parts, 0 = one 128 KB part |
| periph_sel | input | 1 | Route data accesses to peripheral enables |
| part_blk | input | 6 | Partition boundary in 2 KB blocks |
| inhibit | input | 1 | Reset or power-fail hold-off |
| ce_n | output | 4 | Memory chip enables (bits 1 and 2 carry A16 and A15 in the 128 KB build) |
| pe_n | output | 4 | Peripheral enables by address quarter |
| wr_n | output | 1 | Write strobe |
| ba | output | 15 | Byte-wide address |
| ext_sel | output | 1 | Access falls outside the byte-wide ranges |

## Verification
In one cycle, an inhibit can coincide with a write that would otherwise reach memory or a peripheral. The bench provokes this by holding `inhibit` during strobed data writes and program writes. It then judges that `wr_n` and every enable stay high while `ba` still follows the address. The peripheral select also overlaps the partition decode: data addresses below the partition would fall out of range if `periph_sel` were clear. The bench strobes such addresses with the bit set and expects a peripheral enable and no expanded-bus flag. A reference model in the bench, driven with directed and random inputs, compares every output on every clock.

// File: rtl/bw_decoder_pkg.sv
package bw_decoder_pkg;
    localparam int ADDR_W    = 16;
    localparam int BA_W      = 15;
    localparam int PAGE_LOG2 = 11;
    localparam int BLK_W     = ADDR_W - PAGE_LOG2 + 1;
    localparam int LOC_W     = ADDR_W + 1;
    localparam int N_CE      = 4;
    localparam int N_PE      = 4;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_MEM    = 2'd1,
        TGT_PERIPH = 2'd2,
        TGT_EXT    = 2'd3
    } bw_target_e;

    typedef struct packed {
        bw_target_e       tgt;
        logic [LOC_W-1:0] loc;
        logic             wr_ok;
    } bw_route_t;

    typedef struct packed {
        logic [N_CE-1:0] ce_n;
        logic [N_PE-1:0] pe_n;
        logic            wr_n;
        logic            ext_sel;
    } bw_ctrl_t;

    function automatic bw_ctrl_t bw_idle();
        bw_ctrl_t c;
        c.ce_n    = '1;
        c.pe_n    = '1;
        c.wr_n    = 1'b1;
        c.ext_sel = 1'b0;
        return c;
    endfunction
endpackage

// File: rtl/bw_route.sv
module bw_route
    import bw_decoder_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_prog,
    input  logic              wr,
    input  logic              periph_sel,
    input  logic [BLK_W-1:0]  part_blk,
    output bw_route_t         route
);
    logic [LOC_W-1:0] limit;
    logic             below;

    assign limit = {part_blk, {PAGE_LOG2{1'b0}}};
    assign below = ({1'b0, addr} < limit);

    always_comb begin
        route.loc   = {~is_prog, addr};
        route.wr_ok = wr & ~is_prog;
        if (!is_prog && periph_sel)
            route.tgt = TGT_PERIPH;
        else if (is_prog ? below : !below)
            route.tgt = TGT_MEM;
        else
            route.tgt = TGT_EXT;
    end
endmodule

// File: rtl/bw_encode.sv
module bw_encode
    import bw_decoder_pkg::*;
(
    input  bw_route_t route,
    input  logic      mem_big,
    output bw_ctrl_t  ctrl
);
    localparam int SEL_W = $clog2(N_CE);

    logic [N_CE-1:0] ce_small_n;
    logic [N_PE-1:0] pe_dec_n;
    logic [N_CE-1:0] ce_large_n;

    for (genvar i = 0; i < N_CE; i++) begin : g_ce
        assign ce_small_n[i] = (route.loc[LOC_W-1 -: SEL_W] != SEL_W'(i));
    end

    for (genvar j = 0; j < N_PE; j++) begin : g_pe
        assign pe_dec_n[j] = (route.loc[ADDR_W-1 -: 2] != 2'(j));
    end

    assign ce_large_n = {1'b1, route.loc[ADDR_W-1], route.loc[LOC_W-1], 1'b0};

    always_comb begin
        ctrl = bw_idle();
        unique case (route.tgt)
            TGT_MEM: begin
                ctrl.ce_n = mem_big ? ce_small_n : ce_large_n;
                ctrl.wr_n = ~route.wr_ok;
            end
            TGT_PERIPH: begin
                ctrl.pe_n = pe_dec_n;
                ctrl.wr_n = ~route.wr_ok;
            end
            TGT_EXT:  ctrl.ext_sel = 1'b1;
            default:  ctrl = bw_idle();
        endcase
    end
endmodule

// File: rtl/bw_decoder.sv
module bw_decoder
    import bw_decoder_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [15:0]       addr,
    input  logic              is_prog,
    input  logic              wr,
    input  logic              mem_big,
    input  logic              periph_sel,
    input  logic [5:0]        part_blk,
    input  logic              inhibit,
    output logic [3:0]        ce_n,
    output logic [3:0]        pe_n,
    output logic              wr_n,
    output logic [14:0]       ba,
    output logic              ext_sel
);
    bw_route_t route;
    bw_ctrl_t  enc;
    bw_ctrl_t  ctrl_q;
    logic [BA_W-1:0] ba_q;

    bw_route u_route (
        .addr      (addr),
        .is_prog   (is_prog),
        .wr        (wr),
        .periph_sel(periph_sel),
        .part_blk  (part_blk),
        .route     (route)
    );

    bw_encode u_encode (
        .route  (route),
        .mem_big(mem_big),
        .ctrl   (enc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= bw_idle();
            ba_q   <= '0;
        end else begin
            if (strobe)
                ba_q <= addr[BA_W-1:0];
            if (strobe && !inhibit)
                ctrl_q <= enc;
            else
                ctrl_q <= bw_idle();
        end
    end

    assign ce_n    = ctrl_q.ce_n;
    assign pe_n    = ctrl_q.pe_n;
    assign wr_n    = ctrl_q.wr_n;
    assign ext_sel = ctrl_q.ext_sel;
    assign ba      = ba_q;

    // R9
    inhibit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> (&ce_n && &pe_n && wr_n && !ext_sel));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> (&ce_n && &pe_n && wr_n && !ext_sel));

    // R6
    prog_wprot_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && is_prog) |=> wr_n);

    // R3
    big_ce4_off_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_big |=> ce_n[3]);

    // R11
    onehot_small_chk: assert property (@(posedge clk) disable iff (rst)
        mem_big |=> $onehot0({~ce_n, ~pe_n}));

    // R5
    periph_no_ce_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && !is_prog && periph_sel && mem_big) |=> &ce_n);

    // R8
    ext_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ext_sel |-> (&ce_n && &pe_n && wr_n));

    // R7
    ba_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(ba));
endmodule

// File: tb/bw_decoder_tb.sv
module bw_decoder_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        strobe;
    logic [15:0] addr;
    logic        is_prog;
    logic        wr;
    logic        mem_big;
    logic        periph_sel;
    logic [5:0]  part_blk;
    logic        inhibit;
    logic [3:0]  ce_n;
    logic [3:0]  pe_n;
    logic        wr_n;
    logic [14:0] ba;
    logic        ext_sel;

    int checks = 0;
    int errors = 0;

    logic [3:0]  x_ce;
    logic [3:0]  x_pe;
    logic        x_wr;
    logic        x_ext;
    logic [14:0] x_ba;

    always #2.5 clk = ~clk;

    bw_decoder u_dut (
        .clk(clk), .rst(rst), .strobe(strobe), .addr(addr),
        .is_prog(is_prog), .wr(wr), .mem_big(mem_big),
        .periph_sel(periph_sel), .part_blk(part_blk), .inhibit(inhibit),
        .ce_n(ce_n), .pe_n(pe_n), .wr_n(wr_n), .ba(ba), .ext_sel(ext_sel)
    );

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic model();
        int a;
        int lim;
        a   = int'(addr);
        lim = int'(part_blk) * 2048;
        if (strobe) x_ba = addr[14:0];
        x_ce = 4'hF; x_pe = 4'hF; x_wr = 1'b1; x_ext = 1'b0;
        if (strobe && !inhibit) begin
            if (!is_prog && periph_sel) begin
                x_pe[a / 16384] = 1'b0;
                x_wr = !wr;
            end else if (is_prog ? (a < lim) : (a >= lim)) begin
                if (mem_big) begin
                    x_ce[(is_prog ? 0 : 2) + (a >= 32768 ? 1 : 0)] = 1'b0;
                end else begin
                    x_ce[0] = 1'b0;
                    x_ce[1] = !is_prog;
                    x_ce[2] = (a >= 32768);
                    x_ce[3] = 1'b1;
                end
                x_wr = is_prog ? 1'b1 : !wr;
            end else begin
                x_ext = 1'b1;
            end
        end
    endtask

    task automatic compare(input string tag);
        int low;
        checks++;
        if (ce_n !== x_ce || pe_n !== x_pe || wr_n !== x_wr ||
            ext_sel !== x_ext || ba !== x_ba) begin
            errors++;
            $display("FAIL %s: actual ce=%b pe=%b wr=%b ext=%b ba=%h expected ce=%b pe=%b wr=%b ext=%b ba=%h",
                     tag, ce_n, pe_n, wr_n, ext_sel, ba, x_ce, x_pe, x_wr, x_ext, x_ba);
        end
        low = mem_big ? $countones(~{ce_n, pe_n})
                      : $countones(~{ce_n[3], ce_n[0], pe_n});
        checks++;
        if (low > 1) begin
            errors++;
            $display("FAIL R11: actual %0d enables low, expected at most 1", low);
        end
    endtask

    task automatic step(input string tag, input logic s, input logic [15:0] a,
                        input logic p, input logic w, input logic big,
                        input logic ps, input logic [5:0] blk, input logic inh);
        strobe = s; addr = a; is_prog = p; wr = w; mem_big = big;
        periph_sel = ps; part_blk = blk; inhibit = inh;
        model();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        rst = 1'b1; strobe = 1'b0; addr = 16'h0; is_prog = 1'b0; wr = 1'b0;
        mem_big = 1'b1; periph_sel = 1'b0; part_blk = 6'd16; inhibit = 1'b0;
        x_ce = 4'hF; x_pe = 4'hF; x_wr = 1'b1; x_ext = 1'b0; x_ba = 15'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset");
        strobe = 1'b1; addr = 16'h1234;
        @(posedge clk);
        @(negedge clk);
        compare("R1 reset holds");
        rst = 1'b0;
        strobe = 1'b0;

        // 32 KB build, R2
        step("R2 prog low CE1",   1, 16'h0100, 1, 0, 1, 0, 6'd16, 0);
        step("R2 prog high CE2",  1, 16'h9000, 1, 0, 1, 0, 6'd40, 0);
        step("R2 data low CE3",   1, 16'h1000, 0, 0, 1, 0, 6'd0,  0);
        step("R2 R6 data wr CE4", 1, 16'hF00F, 0, 1, 1, 0, 6'd0,  0);
        step("R6 prog write",     1, 16'h0200, 1, 1, 1, 0, 6'd16, 0);
        // partition edges, R4 and R8
        step("R4 R8 prog at limit", 1, 16'h8000, 1, 0, 1, 0, 6'd16, 0);
        step("R4 prog below limit", 1, 16'h7FFF, 1, 0, 1, 0, 6'd16, 0);
        step("R4 R8 data below",    1, 16'h07FF, 0, 1, 1, 0, 6'd1,  0);
        step("R4 data at limit",    1, 16'h0800, 0, 1, 1, 0, 6'd1,  0);
        step("R4 R8 prog blk0",     1, 16'h0000, 1, 0, 1, 0, 6'd0,  0);
        // 128 KB build, R3
        step("R3 prog A15",   1, 16'h9000, 1, 0, 0, 0, 6'd63, 0);
        step("R3 data A16",   1, 16'h8123, 0, 1, 0, 0, 6'd0,  0);
        step("R3 data low",   1, 16'h0123, 0, 0, 0, 0, 6'd0,  0);
        // peripherals, R5
        step("R5 PE1", 1, 16'h0010, 0, 0, 1, 1, 6'd32, 0);
        step("R5 PE2", 1, 16'h4010, 0, 1, 1, 1, 6'd32, 0);
        step("R5 PE3", 1, 16'h8010, 0, 0, 0, 1, 6'd0,  0);
        step("R5 PE4", 1, 16'hC010, 0, 1, 1, 1, 6'd0,  0);
        step("R5 prog ignores sel", 1, 16'h0400, 1, 0, 1, 1, 6'd8, 0);
        // inhibit and idle, R9 R10 R7
        step("R9 inhibit data wr", 1, 16'hA5A5, 0, 1, 1, 0, 6'd0,  1);
        step("R9 inhibit periph",  1, 16'h4444, 0, 1, 1, 1, 6'd0,  1);
        step("R9 inhibit ext",     1, 16'h9999, 1, 0, 0, 0, 6'd1,  1);
        step("R10 R7 no strobe",   0, 16'h3333, 0, 1, 1, 1, 6'd0,  0);
        step("R7 ba update",       1, 16'h7ABC, 0, 0, 1, 0, 6'd0,  0);

        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            step("R2 R3 R4 R5 R6 R8 R9 R10 random",
                 r[0] | r[1], r[31:16], r[2], r[3], r[4], r[5] & r[6],
                 r[12:7], r[13] & r[14] & r[15]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule